// File: doc/BRIEF.md
# Clamped Split-Transaction Timeout Registers

This block holds the two 32-bit words that software or a remote bus agent uses to program the split-transaction timeout. The high word carries whole seconds in three bits. The low word carries a count of bus cycles in its top 13 bits. The block also keeps a registered, combined timeout counted in cycle units, which internal timer logic reads directly.

A single access port handles both words. The write strobe, the word select and the write data are sampled on the rising clock edge. Read data is a combinational view of whichever word is selected. Every write to the low word is forced into a legal range before it is stored. Every write to either word starts a recomputation of the combined timeout, and the new value appears one clock after the registers change.

Top module: `st_split_timeout`

## Requirements
- R1: A write with `acc_sel`=1 stores only bits [2:0] of `acc_wdata` in the high word. Bits [31:3] are discarded.
- R2: A write with `acc_sel`=0 takes the low count from bits [31:19] of `acc_wdata`. Bits [18:0] have no effect.
- R3: A low count below 800 is stored as 800. A count of exactly 800 is kept.
- R4: A low count above 7999 is stored as 7999. A count of exactly 7999 is kept.
- R5: With `acc_sel`=0, `acc_rdata` returns the stored low count in bits [31:19], with bits [18:0] zero.
- R6: With `acc_sel`=1, `acc_rdata` returns the 3-bit high value zero-extended to 32 bits.
- R7: `timeout_cycles` equals high × 8000 + low. After a write is sampled on edge E, the word registers change at E. `timeout_cycles` keeps its old value until edge E+1, when it takes the new sum. Without a write it does not change.
- R8: After reset, the high word is 0 and the low word is `LO_INIT` clamped to 800..7999. The default `LO_INIT` is 500, so the low word reads 800. `timeout_cycles` then equals the matching sum.
- R9: A write to one word leaves the other word unchanged.
- R10: In the cycle a write is presented, `acc_rdata` still shows the value the word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Write strobe, sampled on the rising edge |
| acc_sel | input | 1 | Word select: 1 = high word, 0 = low word |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the selected word |
| timeout_cycles | output | 16 | Registered combined timeout in cycle units |

## Verification
Two things can happen in the same cycle: a write to a word, and a read of that same word. The bench holds `acc_sel` on the word being written. It samples `acc_rdata` while the write is still being presented and expects the pre-write contents. It samples again after the edge and expects the new contents. The same sequence also judges the combined output. `timeout_cycles` is sampled in the cycle right after the registers change, where the old sum is expected, and again one edge later, where the new sum is expected.

// File: rtl/st_pkg.sv
package st_pkg;

    localparam int ST_WORD_W   = 32;
    localparam int ST_LO_SHIFT = 19;
    localparam int ST_LO_W     = ST_WORD_W - ST_LO_SHIFT;
    localparam int ST_HI_W     = 3;

    typedef enum logic {
        ST_SEL_LO = 1'b0,
        ST_SEL_HI = 1'b1
    } st_sel_e;

    typedef struct packed {
        logic                 wr;
        st_sel_e              sel;
        logic [ST_WORD_W-1:0] data;
    } st_access_t;

    typedef struct packed {
        logic [ST_HI_W-1:0] hi;
        logic [ST_LO_W-1:0] lo;
    } st_words_t;

    // Force a count into [mn, mx]
    function automatic logic [ST_LO_W-1:0] st_clamp(input int v, input int mn, input int mx);
        int r;
        r = v;
        if (r < mn) r = mn;
        if (r > mx) r = mx;
        return ST_LO_W'(r);
    endfunction

    // Present a stored word in its bus bit placement
    function automatic logic [ST_WORD_W-1:0] st_view(input st_sel_e sel, input st_words_t w);
        if (sel == ST_SEL_HI)
            return {{(ST_WORD_W-ST_HI_W){1'b0}}, w.hi};
        return {w.lo, {ST_LO_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/st_hi_reg.sv
module st_hi_reg
    import st_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ST_WORD_W-1:0] wdata,
    output logic [ST_HI_W-1:0]   hi_q
);
    always_ff @(posedge clk) begin
        if (rst)
            hi_q <= '0;
        else if (wr_en)
            hi_q <= wdata[ST_HI_W-1:0];
    end
endmodule

// File: rtl/st_lo_reg.sv
module st_lo_reg
    import st_pkg::*;
#(
    parameter int LO_MIN  = 800,
    parameter int LO_MAX  = 7999,
    parameter int LO_INIT = 500
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ST_WORD_W-1:0] wdata,
    output logic [ST_LO_W-1:0]   lo_q
);
    localparam logic [ST_LO_W-1:0] LO_RST = st_clamp(LO_INIT, LO_MIN, LO_MAX);

    logic [ST_LO_W-1:0] raw_cnt;
    logic [ST_LO_W-1:0] lim_cnt;

    always_comb begin
        raw_cnt = wdata[ST_WORD_W-1:ST_LO_SHIFT];
        lim_cnt = st_clamp(int'(raw_cnt), LO_MIN, LO_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst)
            lo_q <= LO_RST;
        else if (wr_en)
            lo_q <= lim_cnt;
    end
endmodule

// File: rtl/st_combine.sv
module st_combine
    import st_pkg::*;
#(
    parameter int CYC_PER_SEC = 8000,
    parameter int TO_W        = 16,
    parameter int RST_VAL     = 800
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd,
    input  logic [ST_HI_W-1:0] hi,
    input  logic [ST_LO_W-1:0] lo,
    output logic [TO_W-1:0]    timeout
);
    logic [TO_W-1:0] sum;

    always_comb begin
        sum = TO_W'(hi) * TO_W'(CYC_PER_SEC) + TO_W'(lo);
    end

    always_ff @(posedge clk) begin
        if (rst)
            timeout <= TO_W'(RST_VAL);
        else if (upd)
            timeout <= sum;
    end
endmodule

// File: rtl/st_split_timeout.sv
module st_split_timeout
    import st_pkg::*;
#(
    parameter int LO_MIN      = 800,
    parameter int LO_MAX      = 7999,
    parameter int LO_INIT     = 500,
    parameter int CYC_PER_SEC = 8000,
    parameter int TO_W        = $clog2(((1 << ST_HI_W) - 1) * CYC_PER_SEC + LO_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_wr,
    input  logic                 acc_sel,
    input  logic [ST_WORD_W-1:0] acc_wdata,
    output logic [ST_WORD_W-1:0] acc_rdata,
    output logic [TO_W-1:0]      timeout_cycles
);
    localparam int LO_RST = int'(st_clamp(LO_INIT, LO_MIN, LO_MAX));

    st_access_t acc;
    st_words_t  words;
    logic       wr_hi;
    logic       wr_lo;
    logic       upd_q;

    always_comb begin
        acc.wr   = acc_wr;
        acc.sel  = st_sel_e'(acc_sel);
        acc.data = acc_wdata;
        wr_hi    = acc.wr && (acc.sel == ST_SEL_HI);
        wr_lo    = acc.wr && (acc.sel == ST_SEL_LO);
    end

    st_hi_reg u_hi (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_hi),
        .wdata (acc.data),
        .hi_q  (words.hi)
    );

    st_lo_reg #(
        .LO_MIN  (LO_MIN),
        .LO_MAX  (LO_MAX),
        .LO_INIT (LO_INIT)
    ) u_lo (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_lo),
        .wdata (acc.data),
        .lo_q  (words.lo)
    );

    // Recompute the sum on the cycle after any write
    always_ff @(posedge clk) begin
        if (rst)
            upd_q <= 1'b0;
        else
            upd_q <= acc.wr;
    end

    st_combine #(
        .CYC_PER_SEC (CYC_PER_SEC),
        .TO_W        (TO_W),
        .RST_VAL     (LO_RST)
    ) u_comb (
        .clk     (clk),
        .rst     (rst),
        .upd     (upd_q),
        .hi      (words.hi),
        .lo      (words.lo),
        .timeout (timeout_cycles)
    );

    assign acc_rdata = st_view(acc.sel, words);

endmodule

// File: rtl/st_split_timeout_chk.sv
module st_split_timeout_chk
    import st_pkg::*;
#(
    parameter int LO_MIN      = 800,
    parameter int LO_MAX      = 7999,
    parameter int CYC_PER_SEC = 8000,
    parameter int TO_W        = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 acc_wr,
    input logic                 acc_sel,
    input logic [ST_WORD_W-1:0] acc_rdata,
    input logic [ST_HI_W-1:0]   hi_q,
    input logic [ST_LO_W-1:0]   lo_q,
    input logic                 upd_q,
    input logic [TO_W-1:0]      timeout_cycles
);
    AST_HI_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        acc_sel |-> (acc_rdata[ST_WORD_W-1:ST_HI_W] == '0)); // R6

    AST_LO_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !acc_sel |-> (acc_rdata[ST_LO_SHIFT-1:0] == '0)); // R5

    AST_LO_ABOVE_MIN: assert property (@(posedge clk) disable iff (rst)
        int'(lo_q) >= LO_MIN); // R3

    AST_LO_BELOW_MAX: assert property (@(posedge clk) disable iff (rst)
        int'(lo_q) <= LO_MAX); // R4

    AST_SUM_TRACKS: assert property (@(posedge clk) disable iff (rst)
        upd_q |=> (timeout_cycles ==
                   TO_W'($past(hi_q)) * TO_W'(CYC_PER_SEC) + TO_W'($past(lo_q)))); // R7

    AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !upd_q |=> $stable(timeout_cycles)); // R7

    AST_HI_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && !acc_sel) |=> $stable(hi_q)); // R9

    AST_LO_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && acc_sel) |=> $stable(lo_q)); // R9

endmodule

bind st_split_timeout st_split_timeout_chk #(
    .LO_MIN      (LO_MIN),
    .LO_MAX      (LO_MAX),
    .CYC_PER_SEC (CYC_PER_SEC),
    .TO_W        (TO_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .acc_wr         (acc_wr),
    .acc_sel        (acc_sel),
    .acc_rdata      (acc_rdata),
    .hi_q           (words.hi),
    .lo_q           (words.lo),
    .upd_q          (upd_q),
    .timeout_cycles (timeout_cycles)
);

// File: tb/sim_st_split_timeout.sv
`timescale 1ns/1ps
module sim_st_split_timeout;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_wr = 1'b0;
    logic        acc_sel = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [15:0] timeout_cycles;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    st_split_timeout u0 (
        .clk            (clk),
        .rst            (rst),
        .acc_wr         (acc_wr),
        .acc_sel        (acc_sel),
        .acc_wdata      (acc_wdata),
        .acc_rdata      (acc_rdata),
        .timeout_cycles (timeout_cycles)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        @(negedge clk);
        acc_sel = sel;
        #1 v = acc_rdata;
    endtask

    // Write; after return regs hold the new value, sum not yet updated
    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_sel = sel; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0; acc_wdata = '0;
    endtask

    function automatic logic [31:0] lo_word(input int c);
        return 32'(c) << 19;
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        rd(1'b1, v); chk("R8 hi after reset", v, 32'd0);
        rd(1'b0, v); chk("R8 lo after reset", v, lo_word(800));
        chk("R8 sum after reset", 32'(timeout_cycles), 32'd800);
    endtask

    task automatic t_hi_write;
        logic [31:0] v;
        wr(1'b1, 32'hFFFF_FFFD);
        rd(1'b1, v); chk("R1 hi keeps 3 bits", v, 32'd5);
        chk("R6 hi zero-extended", v & 32'hFFFF_FFF8, 32'd0);
        rd(1'b0, v); chk("R9 lo untouched by hi write", v, lo_word(800));
        chk("R7 sum after hi write", 32'(timeout_cycles), 32'd40800);
    endtask

    task automatic t_lo_write;
        logic [31:0] v;
        wr(1'b0, lo_word(3000) | 32'h0007_FFFF);
        rd(1'b0, v); chk("R2 low bits ignored", v, lo_word(3000));
        chk("R5 lo read low bits zero", v & 32'h0007_FFFF, 32'd0);
        rd(1'b1, v); chk("R9 hi untouched by lo write", v, 32'd5);
        chk("R7 sum after lo write", 32'(timeout_cycles), 32'd43000);
    endtask

    task automatic t_clamp;
        logic [31:0] v;
        wr(1'b0, 32'd0);          rd(1'b0, v); chk("R3 zero clamps", v, lo_word(800));
        wr(1'b0, lo_word(799));   rd(1'b0, v); chk("R3 799 clamps", v, lo_word(800));
        wr(1'b0, lo_word(800));   rd(1'b0, v); chk("R3 800 kept", v, lo_word(800));
        wr(1'b0, lo_word(8191));  rd(1'b0, v); chk("R4 8191 clamps", v, lo_word(7999));
        wr(1'b0, lo_word(8000));  rd(1'b0, v); chk("R4 8000 clamps", v, lo_word(7999));
        wr(1'b0, lo_word(7999));  rd(1'b0, v); chk("R4 7999 kept", v, lo_word(7999));
    endtask

    task automatic t_same_cycle;
        logic [31:0] v;
        // hi=5, lo=7999 now; write hi=7 and look before and after the edge
        @(negedge clk);
        acc_wr = 1'b1; acc_sel = 1'b1; acc_wdata = 32'd7;
        #1 chk("R10 read during write shows old", acc_rdata, 32'd5);
        @(negedge clk);
        acc_wr = 1'b0;
        #1 chk("R10 read after edge shows new", acc_rdata, 32'd7);
        chk("R7 sum still old one cycle after", 32'(timeout_cycles), 32'd47999);
        @(negedge clk);
        #1 chk("R7 sum new two edges after", 32'(timeout_cycles), 32'd63999);
        rd(1'b0, v);
        repeat (3) @(negedge clk);
        chk("R7 sum holds without writes", 32'(timeout_cycles), 32'd63999);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hi_write();
        t_lo_write();
        t_clamp();
        t_same_cycle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule